// File: doc/BRIEF.md
# 8b/10b Symbol Decoder with In-Band Error Marking

The block turns aligned 10-bit line symbols into an 8-bit byte plus a control-character flag. It keeps a running-disparity state across symbols and checks each symbol against the legal code set for that state. The 6-bit and 4-bit sub-symbols are decoded on their own, and the disparity state is advanced after each of them.

A symbol that breaks the code leaves the block as the control byte 0xEE with the control flag set. This gives downstream logic an error marker inside the data stream, and separate code-error and disparity-error flags say what went wrong. A bypass input lets the raw 10-bit symbol through untouched, so the same channel can carry undecoded traffic.

All outputs are registered. They appear one clock after an input strobe and are qualified by an output strobe.

Top module: `dec8b10b`

## Requirements
- R1: After reset `valid_o` is 0 and the running disparity is negative, so a first symbol taken from the negative-disparity column decodes with no error.
- R2: Input bit order is `data_i[0]`=a, [1]=b, [2]=c, [3]=d, [4]=e, [5]=i, [6]=f, [7]=g, [8]=h, [9]=j. A legal data symbol gives `data_o[7:0]` = HGFEDCBA with `data_o[9:8]`=0 and `ctrl_o`=0. The twelve control symbols (K28.0–K28.7, K23.7, K27.7, K29.7, K30.7) set `ctrl_o`=1.
- R3: `valid_o` is high exactly in the cycle after each cycle in which `valid_i` is high, and carries that symbol's results.
- R4: The disparity state is updated after each sub-symbol from the received bits. More ones than zeros makes it positive, fewer makes it negative, and a balanced sub-symbol leaves it unchanged. This also applies to symbols with errors.
- R5: A symbol whose sub-symbols are legal only for the opposite disparity sets `disp_err_o`=1 and `code_err_o`=0.
- R6: A symbol that is not legal at either disparity sets `code_err_o`=1 and `disp_err_o`=0. This includes a sub-symbol with an illegal weight, the primary x.7 form where the alternate form is required, and a K28 6-bit sub-symbol followed by a non-control 4-bit sub-symbol.
- R7: When either error flag is set, `data_o` = 0x0EE and `ctrl_o` = 1.
- R8: With `bypass_i`=1, `data_o` equals the raw 10-bit input, `ctrl_o` and both error flags are 0, and the disparity state is not changed.
- R9: Cycles with `valid_i` low leave the disparity state unchanged.
- R10: x.7 data uses the alternate 4-bit form for x = 17, 18, 20 when the disparity after the 6-bit sub-symbol is negative, and for x = 11, 13, 14 when it is positive. These symbols decode as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input symbol strobe |
| bypass_i | input | 1 | Pass the raw symbol without decoding |
| data_i | input | 10 | Aligned line symbol, bit 0 = a |
| valid_o | output | 1 | Output strobe, one cycle after `valid_i` |
| data_o | output | 10 | Decoded byte (zero-extended) or raw symbol |
| ctrl_o | output | 1 | Control-character flag |
| code_err_o | output | 1 | Symbol outside the code |
| disp_err_o | output | 1 | Symbol legal only at the opposite disparity |

## Verification
Each result (byte, control flag, error flags and the raw symbol in bypass) is due exactly one clock after the strobed input. A disparity change made by that symbol shows only in how the next strobed symbol is classified. Every expected entry is stamped with the cycle number in which it must appear. The monitor samples two nanoseconds after each rising edge, requires `valid_o` in that exact cycle, and flags any output strobe that has no entry due. The bench keeps its own disparity state, advanced from the bits it sends, so a wrong update surfaces as a spurious or missing disparity error on a later symbol.

// File: rtl/dec8b10b_pkg.sv
package dec8b10b_pkg;
  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 6;
  localparam int LO_W   = 4;
  localparam int X_N    = 1 << (HI_W - 1);
  localparam int Y_N    = 1 << (LO_W - 1);

  typedef struct packed {
    logic       ok;
    logic [2:0] y;
    logic       kf;
  } lo_res_t;

  // negative-column 6-bit codes, written abcdei with a as msb
  function automatic logic [5:0] tbl6(input logic [4:0] x);
    case (x)
      5'd0:  tbl6 = 6'b100111; 5'd1:  tbl6 = 6'b011101;
      5'd2:  tbl6 = 6'b101101; 5'd3:  tbl6 = 6'b110001;
      5'd4:  tbl6 = 6'b110101; 5'd5:  tbl6 = 6'b101001;
      5'd6:  tbl6 = 6'b011001; 5'd7:  tbl6 = 6'b111000;
      5'd8:  tbl6 = 6'b111001; 5'd9:  tbl6 = 6'b100101;
      5'd10: tbl6 = 6'b010101; 5'd11: tbl6 = 6'b110100;
      5'd12: tbl6 = 6'b001101; 5'd13: tbl6 = 6'b101100;
      5'd14: tbl6 = 6'b011100; 5'd15: tbl6 = 6'b010111;
      5'd16: tbl6 = 6'b011011; 5'd17: tbl6 = 6'b100011;
      5'd18: tbl6 = 6'b010011; 5'd19: tbl6 = 6'b110010;
      5'd20: tbl6 = 6'b001011; 5'd21: tbl6 = 6'b101010;
      5'd22: tbl6 = 6'b011010; 5'd23: tbl6 = 6'b111010;
      5'd24: tbl6 = 6'b110011; 5'd25: tbl6 = 6'b100110;
      5'd26: tbl6 = 6'b010110; 5'd27: tbl6 = 6'b110110;
      5'd28: tbl6 = 6'b001110; 5'd29: tbl6 = 6'b101110;
      5'd30: tbl6 = 6'b011110; default: tbl6 = 6'b101011;
    endcase
  endfunction

  function automatic logic [5:0] enc6(input logic [4:0] x, input logic rd);
    logic [5:0] c;
    c = tbl6(x);
    if (rd && (($countones(c) != 3) || (x == 5'd7))) c = ~c;
    return c;
  endfunction

  function automatic logic [5:0] enc6_k28(input logic rd);
    return rd ? 6'b110000 : 6'b001111;
  endfunction

  function automatic logic [3:0] tbl4(input logic [2:0] y);
    case (y)
      3'd0: tbl4 = 4'b1011; 3'd1: tbl4 = 4'b1001;
      3'd2: tbl4 = 4'b0101; 3'd3: tbl4 = 4'b1100;
      3'd4: tbl4 = 4'b1101; 3'd5: tbl4 = 4'b1010;
      3'd6: tbl4 = 4'b0110; default: tbl4 = 4'b1110;
    endcase
  endfunction

  // k: K28 flavour, balanced forms invert at negative disparity
  function automatic logic [3:0] enc4(input logic [2:0] y, input logic rd,
                                      input logic alt, input logic k);
    logic [3:0] c;
    c = alt ? 4'b0111 : tbl4(y);
    if (($countones(c) != 2) || (y == 3'd3)) begin
      if (rd) c = ~c;
    end else if (k && !rd) begin
      c = ~c;
    end
    return c;
  endfunction

  function automatic logic a7_req(input logic [4:0] x, input logic rd);
    return rd ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
              : (x == 5'd17 || x == 5'd18 || x == 5'd20);
  endfunction

  function automatic logic k_alt(input logic [4:0] x);
    return x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30;
  endfunction
endpackage

// File: rtl/dec_hi6.sv
module dec_hi6
  import dec8b10b_pkg::*;
(
  input  logic [5:0] code_i,
  input  logic       rd_i,
  output logic [4:0] val_o,
  output logic       hit_cur_o,
  output logic       hit_opp_o,
  output logic       k28_o,
  output logic       rd_o
);
  logic [4:0] x_cur, x_opp;
  logic [2:0] ones;

  always_comb begin
    hit_cur_o = 1'b0;
    hit_opp_o = 1'b0;
    x_cur     = '0;
    x_opp     = '0;
    for (int i = 0; i < X_N; i++) begin
      if (code_i == enc6(5'(i), rd_i)) begin
        hit_cur_o = 1'b1;
        x_cur     = 5'(i);
      end
      if (code_i == enc6(5'(i), !rd_i)) begin
        hit_opp_o = 1'b1;
        x_opp     = 5'(i);
      end
    end
    k28_o = 1'b0;
    if (code_i == enc6_k28(rd_i)) begin
      hit_cur_o = 1'b1;
      x_cur     = 5'd28;
      k28_o     = 1'b1;
    end
    if (code_i == enc6_k28(!rd_i)) begin
      hit_opp_o = 1'b1;
      x_opp     = 5'd28;
      k28_o     = 1'b1;
    end
    val_o = hit_cur_o ? x_cur : x_opp;
  end

  assign ones = 3'($countones(code_i));
  assign rd_o = (ones > 3'd3) ? 1'b1 : (ones < 3'd3) ? 1'b0 : rd_i;
endmodule

// File: rtl/dec_lo4.sv
module dec_lo4
  import dec8b10b_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       rd_i,
  input  logic [4:0] x_i,
  input  logic       k28_i,
  output logic [2:0] val_o,
  output logic       hit_cur_o,
  output logic       hit_opp_o,
  output logic       ctrl_o,
  output logic       rd_o
);
  lo_res_t r_cur, r_opp;
  logic [2:0] ones;

  function automatic lo_res_t match(input logic [3:0] c, input logic rd,
                                    input logic [4:0] x, input logic k28);
    lo_res_t r;
    r = '0;
    for (int i = 0; i < Y_N; i++) begin
      if (k28) begin
        if (c == enc4(3'(i), rd, i == Y_N - 1, 1'b1)) begin
          r.ok = 1'b1; r.y = 3'(i); r.kf = 1'b1;
        end
      end else if (i != Y_N - 1) begin
        if (c == enc4(3'(i), rd, 1'b0, 1'b0)) begin
          r.ok = 1'b1; r.y = 3'(i); r.kf = 1'b0;
        end
      end else begin
        // primary x.7 form is illegal where the alternate is required
        if (c == enc4(3'd7, rd, 1'b0, 1'b0) && !a7_req(x, rd)) begin
          r.ok = 1'b1; r.y = 3'd7; r.kf = 1'b0;
        end
        if (c == enc4(3'd7, rd, 1'b1, 1'b0) && (a7_req(x, rd) || k_alt(x))) begin
          r.ok = 1'b1; r.y = 3'd7; r.kf = !a7_req(x, rd);
        end
      end
    end
    return r;
  endfunction

  always_comb begin
    r_cur = match(code_i, rd_i, x_i, k28_i);
    r_opp = match(code_i, !rd_i, x_i, k28_i);
  end

  assign hit_cur_o = r_cur.ok;
  assign hit_opp_o = r_opp.ok;
  assign val_o     = r_cur.ok ? r_cur.y  : r_opp.y;
  assign ctrl_o    = r_cur.ok ? r_cur.kf : r_opp.kf;
  assign ones      = 3'($countones(code_i));
  assign rd_o      = (ones > 3'd2) ? 1'b1 : (ones < 3'd2) ? 1'b0 : rd_i;
endmodule

// File: rtl/dec8b10b.sv
module dec8b10b
  import dec8b10b_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SUB_BYTE = 8'hEE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             bypass_i,
  input  logic [SYM_W-1:0] data_i,
  output logic             valid_o,
  output logic [SYM_W-1:0] data_o,
  output logic             ctrl_o,
  output logic             code_err_o,
  output logic             disp_err_o
);
  localparam int PAD_W = SYM_W - BYTE_W;

  logic [HI_W-1:0] hi_code;
  logic [LO_W-1:0] lo_code;
  logic [4:0]      x_val;
  logic [2:0]      y_val;
  logic            rd_q, rd_mid, rd_end;
  logic            h6_cur, h6_opp, h4_cur, h4_opp, k28, ctrl_lo;
  logic            code_err, disp_err;

  // line order a..i then f..j; sub-codes kept with a (or f) as msb
  always_comb begin
    for (int i = 0; i < HI_W; i++) hi_code[HI_W-1-i] = data_i[i];
    for (int i = 0; i < LO_W; i++) lo_code[LO_W-1-i] = data_i[HI_W+i];
  end

  dec_hi6 u_hi (
    .code_i    (hi_code),
    .rd_i      (rd_q),
    .val_o     (x_val),
    .hit_cur_o (h6_cur),
    .hit_opp_o (h6_opp),
    .k28_o     (k28),
    .rd_o      (rd_mid)
  );

  dec_lo4 u_lo (
    .code_i    (lo_code),
    .rd_i      (rd_mid),
    .x_i       (x_val),
    .k28_i     (k28),
    .val_o     (y_val),
    .hit_cur_o (h4_cur),
    .hit_opp_o (h4_opp),
    .ctrl_o    (ctrl_lo),
    .rd_o      (rd_end)
  );

  assign code_err = !(h6_cur || h6_opp) || !(h4_cur || h4_opp);
  assign disp_err = (h6_opp && !h6_cur) || (h4_opp && !h4_cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= 1'b0;
      valid_o    <= 1'b0;
      data_o     <= '0;
      ctrl_o     <= 1'b0;
      code_err_o <= 1'b0;
      disp_err_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        if (bypass_i) begin
          data_o     <= data_i;
          ctrl_o     <= 1'b0;
          code_err_o <= 1'b0;
          disp_err_o <= 1'b0;
        end else begin
          rd_q       <= rd_end;
          code_err_o <= code_err;
          disp_err_o <= disp_err && !code_err;
          if (code_err || disp_err) begin
            data_o <= {{PAD_W{1'b0}}, SUB_BYTE};
            ctrl_o <= 1'b1;
          end else begin
            data_o <= {{PAD_W{1'b0}}, y_val, x_val};
            ctrl_o <= ctrl_lo;
          end
        end
      end
    end
  end

  // R7
  subst_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (code_err_o || disp_err_o) |-> data_o == {{PAD_W{1'b0}}, SUB_BYTE} && ctrl_o);

  // R8
  bypass_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bypass_i |=> data_o == $past(data_i) && !ctrl_o && !code_err_o && !disp_err_o);

  // R8
  bypass_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bypass_i |=> rd_q == $past(rd_q));

  // R9
  idle_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rd_q));

  // R2
  legal_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i |=> code_err_o || ($countones($past(data_i)) >= 4 && $countones($past(data_i)) <= 6));

  // R5
  both_side_balanced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h6_cur && h6_opp |-> $countones(hi_code) == 3);

  // R3
  strobe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
endmodule

// File: tb/dec8b10b_bench.sv
module dec8b10b_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       bypass_i = 1'b0;
  logic [9:0] data_i = '0;
  logic       valid_o, ctrl_o, code_err_o, disp_err_o;
  logic [9:0] data_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  logic rd_m = 1'b0;

  logic [12:0] q_exp[$];
  int          q_cyc[$];
  string       q_req[$];

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dec8b10b u_dec8b10b (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .bypass_i(bypass_i),
    .data_i(data_i), .valid_o(valid_o), .data_o(data_o), .ctrl_o(ctrl_o),
    .code_err_o(code_err_o), .disp_err_o(disp_err_o)
  );

  // bench-side encoder, abcdei with a as msb
  function automatic logic [5:0] m6(input int x);
    logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101,
      6'b101001, 6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
      6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011,
      6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010, 6'b110011, 6'b100110,
      6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] m4(input int y);
    logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return t[y];
  endfunction

  function automatic logic [9:0] pack(input logic [5:0] c6, input logic [3:0] c4);
    logic [9:0] w;
    for (int i = 0; i < 6; i++) w[i] = c6[5-i];
    for (int i = 0; i < 4; i++) w[6+i] = c4[3-i];
    return w;
  endfunction

  function automatic logic [9:0] encode(input logic [7:0] b, input logic k, input logic rd);
    int x, y;
    logic [5:0] c6;
    logic [3:0] c4;
    logic rdm, alt;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    c6 = (k && x == 28) ? 6'b001111 : m6(x);
    if (rd && ($countones(c6) != 3 || (x == 7 && !k))) c6 = ~c6;
    rdm = ($countones(c6) > 3) ? 1'b1 : ($countones(c6) < 3) ? 1'b0 : rd;
    alt = (y == 7) && (k || (!rdm && (x == 17 || x == 18 || x == 20)) ||
                       (rdm && (x == 11 || x == 13 || x == 14)));
    c4 = alt ? 4'b0111 : m4(y);
    if ($countones(c4) != 2 || y == 3) begin
      if (rdm) c4 = ~c4;
    end else if (k && !rdm) begin
      c4 = ~c4;
    end
    return pack(c6, c4);
  endfunction

  function automatic logic rd_after(input logic [9:0] w, input logic rd);
    logic r;
    r = ($countones(w[5:0]) > 3) ? 1'b1 : ($countones(w[5:0]) < 3) ? 1'b0 : rd;
    r = ($countones(w[9:6]) > 2) ? 1'b1 : ($countones(w[9:6]) < 2) ? 1'b0 : r;
    return r;
  endfunction

  task automatic apply(input logic [9:0] w, input logic byp, input logic [12:0] exp_v, input string req);
    @(negedge clk_i);
    valid_i  = 1'b1;
    bypass_i = byp;
    data_i   = w;
    q_exp.push_back(exp_v);
    q_cyc.push_back(cyc + 1);
    q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (n - 1) @(negedge clk_i);
  endtask

  task automatic send_dec(input logic [7:0] b, input logic k, input logic opp, input string req);
    logic [9:0] w;
    w = encode(b, k, opp ? !rd_m : rd_m);
    if (w == encode(b, k, rd_m)) apply(w, 1'b0, {2'b00, b, k, 1'b0, 1'b0}, req);
    else                         apply(w, 1'b0, {10'h0EE, 1'b1, 1'b0, 1'b1}, req);
    rd_m = rd_after(w, rd_m);
  endtask

  task automatic send_bad(input logic [9:0] w, input string req);
    apply(w, 1'b0, {10'h0EE, 1'b1, 1'b1, 1'b0}, req);
    rd_m = rd_after(w, rd_m);
  endtask

  // monitor: scoreboard pop, each item due in its stamped cycle (R3)
  always begin
    @(posedge clk_i);
    #2;
    if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      logic [12:0] e;
      string r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      void'(q_cyc.pop_front());
      checks++;
      if (!valid_o || {data_o, ctrl_o, code_err_o, disp_err_o} != e) begin
        fails++;
        $display("FAIL %s R3: got v=%b d=%h k=%b ce=%b de=%b exp v=1 d=%h k=%b ce=%b de=%b",
                 r, valid_o, data_o, ctrl_o, code_err_o, disp_err_o, e[12:3], e[2], e[1], e[0]);
      end
    end else if (valid_o) begin
      checks++;
      fails++;
      $display("FAIL R3: got valid_o=1 exp valid_o=0 at cycle %0d", cyc);
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog: got no completion exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: got valid_o=%b exp 0", valid_o);
    end
    rst_ni = 1'b1;
    idle(2);
    // R1: negative start, K28.5 from the negative column
    send_dec(8'hBC, 1'b1, 1'b0, "R1");
    // R2 R4 R10: every data byte at the tracked disparity
    for (int b = 0; b < 256; b++) send_dec(8'(b), 1'b0, 1'b0, "R2 R4 R10");
    // R2: control symbols
    for (int y = 0; y < 8; y++) send_dec({3'(y), 5'd28}, 1'b1, 1'b0, "R2");
    send_dec(8'hF7, 1'b1, 1'b0, "R2");
    send_dec(8'hFB, 1'b1, 1'b0, "R2");
    send_dec(8'hFD, 1'b1, 1'b0, "R2");
    send_dec(8'hFE, 1'b1, 1'b0, "R2");
    // R5 R7: every byte encoded for the opposite disparity
    for (int b = 0; b < 256; b++) send_dec(8'(b), 1'b0, 1'b1, "R5 R7");
    for (int y = 0; y < 8; y++) send_dec({3'(y), 5'd28}, 1'b1, 1'b1, "R5 R7");
    // R10: alternate x.7 forms at both disparities
    for (int n = 0; n < 3; n++) begin
      send_dec(8'hF1, 1'b0, 1'b0, "R10");
      send_dec(8'hEB, 1'b0, 1'b0, "R10");
      send_dec(8'hF2, 1'b0, 1'b0, "R10");
      send_dec(8'hED, 1'b0, 1'b0, "R10");
      send_dec(8'hF4, 1'b0, 1'b0, "R10");
      send_dec(8'hEE, 1'b0, 1'b0, "R10");
    end
    // R6 R7: illegal weights
    send_bad(10'h000, "R6 R7");
    send_bad(10'h3FF, "R6 R7");
    send_bad(pack(6'b111111, 4'b1001), "R6 R7");
    send_bad(pack(6'b100011, 4'b1111), "R6 R7");
    // R6: primary x.7 where alternate required, K28 with data-only 4b
    for (int n = 0; n < 2; n++) begin
      if (!rd_m) send_bad(pack(6'b100011, 4'b1110), "R6 R10");
      else       send_bad(pack(6'b110100, 4'b0001), "R6 R10");
      if (!rd_m) send_bad(pack(6'b001111, 4'b0001), "R6");
      else       send_bad(pack(6'b110000, 4'b1110), "R6");
      send_dec(8'h00, 1'b0, 1'b0, "R4");
    end
    // R9: gaps keep the disparity
    idle(3);
    send_dec(8'hBC, 1'b1, 1'b0, "R9");
    idle(5);
    send_dec(8'h00, 1'b0, 1'b0, "R9");
    send_dec(8'hBC, 1'b1, 1'b0, "R9");
    // R8: bypass passes raw and leaves disparity alone
    for (int n = 0; n < 2; n++) begin
      apply(10'h3FF, 1'b1, {10'h3FF, 3'b000}, "R8");
      apply(10'h000, 1'b1, {10'h000, 3'b000}, "R8");
      apply(10'h2A5, 1'b1, {10'h2A5, 3'b000}, "R8");
      send_dec(8'hBC, 1'b1, 1'b0, "R8");
      send_dec(8'h1C, 1'b1, 1'b0, "R8");
    end
    idle(4);
    checks++;
    if (q_exp.size() != 0) begin
      fails++;
      $display("FAIL R3: got %0d pending results exp 0", q_exp.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule